// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

The block turns a four-bit binary-coded-decimal digit into the seven active-high segment lines of one display digit. A hold register sits in front of the decoder. While the hold control is low, the decoder follows the digit input directly. While the hold control is high, the decoder shows the last digit taken in. Codes above nine produce a dark digit.

Three controls act on top of the decoded digit. A lamp-test input lights every segment. A blanking input darkens the digit and can be pulsed to dim the display. A ripple-blank pair chains digits together so that zeros are suppressed. A digit whose ripple input is high and whose code is zero stays dark and raises its ripple output. The next digit in the chain then treats that output as its own ripple input. This suppresses leading zeros, or trailing zeros when the chain runs the other way.

All outputs are registered. Each output shows the result for the inputs of the previous clock edge.

Top module: `bcd7_latch_decoder`

## Requirements
- R1: While `lamp_test_ni` is 0, `seg_o` becomes 7'h7F and `ripple_o` becomes 0, whatever the other inputs and the stored digit are.
- R2: While `lamp_test_ni` is 1 and `blank_ni` is 0, `seg_o` becomes 7'h00, whatever the digit and the stored code are.
- R3: The code seen by the decoder is `digit_i` at an edge where `hold_i` is 0. At an edge where `hold_i` is 1, it is the `digit_i` value from the last edge where `hold_i` was 0. Reset clears the stored code to 0.
- R4: With lamp test and blanking inactive, codes 10 to 15 give `seg_o` = 7'h00.
- R5: With lamp test and blanking inactive, `ripple_i` at 1 and a code of 0 give `seg_o` = 7'h00 and `ripple_o` = 1.
- R6: With lamp test and blanking inactive, `ripple_i` at 0 and a code of 0 give `seg_o` = 7'h3F (segments a to f on, g off).
- R7: `seg_o` bit 0 is segment a, and so on up to bit 6, which is segment g. The codes 1 to 9 give 06, 5B, 4F, 66, 6D, 7C, 07, 7F, 67 (hex) when the controls are inactive. Code 6 has no top bar and code 9 has no bottom bar.
- R8: When `lamp_test_ni` is 1, `ripple_o` is `ripple_i` AND (code == 0). This holds even while `blank_ni` is 0.
- R9: The outputs are registered. They reflect the inputs sampled at the previous rising edge of `clk_i`. During reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digit_i | input | 4 | BCD digit; bit 3 is most significant |
| hold_i | input | 1 | 1 holds the stored code; 0 passes and stores `digit_i` |
| lamp_test_ni | input | 1 | Active-low lamp test |
| blank_ni | input | 1 | Active-low blanking |
| ripple_i | input | 1 | Ripple-blank input from the neighbouring digit |
| seg_o | output | 7 | Segments a (bit 0) to g (bit 6), active high |
| ripple_o | output | 1 | Ripple-blank output to the neighbouring digit |

## Verification
A stored code that is wrong or lost can only show while `hold_i` is high. It appears one edge later as a wrong glyph, or as a wrong `ripple_o` when the digit involved is zero. It can be hidden completely by lamp test or blanking.

For this reason the bench loads every code and then holds it while sweeping every control and every digit value. Any corruption of the stored code is then seen in the very next output sample. The bench also sweeps every combination of inputs in transparent mode, so each priority rule is checked against every code.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SEG_W  = 7;
  localparam int unsigned MAX_DIGIT = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  localparam seg_t SEG_ALL  = {SEG_W{1'b1}};
  localparam seg_t SEG_NONE = '0;

  // bit0 = a ... bit6 = g
  function automatic seg_t glyph(input code_t c);
    seg_t s;
    unique case (c)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7C;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h67;
      default: s = SEG_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/bcd7_hold.sv
module bcd7_hold #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] store_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      store_q <= '0;
    else if (!hold_i) store_q <= d_i;
  end

  // transparent while hold is low
  assign code_o = hold_i ? store_q : d_i;
endmodule

// File: rtl/bcd7_glyph.sv
module bcd7_glyph
  import bcd7_pkg::*;
(
  input  code_t code_i,
  output seg_t  seg_o,
  output logic  zero_o,
  output logic  legal_o
);
  assign legal_o = (code_i <= code_t'(MAX_DIGIT));
  assign zero_o  = (code_i == '0);
  assign seg_o   = glyph(code_i);
endmodule

// File: rtl/bcd7_blank.sv
module bcd7_blank
  import bcd7_pkg::*;
(
  input  seg_t seg_i,
  input  logic zero_i,
  input  logic legal_i,
  input  logic lamp_test_ni,
  input  logic blank_ni,
  input  logic ripple_i,
  output seg_t seg_o,
  output logic ripple_o
);
  logic suppress;
  assign suppress = ripple_i & zero_i;

  always_comb begin
    if (!lamp_test_ni)             seg_o = SEG_ALL;
    else if (!blank_ni)            seg_o = SEG_NONE;
    else if (!legal_i || suppress) seg_o = SEG_NONE;
    else                           seg_o = seg_i;
  end

  assign ripple_o = lamp_test_ni & suppress;
endmodule

// File: rtl/bcd7_latch_decoder.sv
module bcd7_latch_decoder
  import bcd7_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] digit_i,
  input  logic              hold_i,
  input  logic              lamp_test_ni,
  input  logic              blank_ni,
  input  logic              ripple_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic              ripple_o
);
  code_t code;
  seg_t  raw_seg, seg_d, seg_q;
  logic  is_zero, is_legal, rip_d, rip_q;

  bcd7_hold #(.W(CODE_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold_i),
    .d_i    (digit_i),
    .code_o (code)
  );

  bcd7_glyph u_glyph (
    .code_i  (code),
    .seg_o   (raw_seg),
    .zero_o  (is_zero),
    .legal_o (is_legal)
  );

  bcd7_blank u_blank (
    .seg_i        (raw_seg),
    .zero_i       (is_zero),
    .legal_i      (is_legal),
    .lamp_test_ni (lamp_test_ni),
    .blank_ni     (blank_ni),
    .ripple_i     (ripple_i),
    .seg_o        (seg_d),
    .ripple_o     (rip_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= SEG_NONE;
      rip_q <= 1'b0;
    end else begin
      seg_q <= seg_d;
      rip_q <= rip_d;
    end
  end

  assign seg_o    = seg_q;
  assign ripple_o = rip_q;
endmodule

// File: rtl/bcd7_latch_decoder_chk.sv
module bcd7_latch_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] digit_i,
  input logic       hold_i,
  input logic       lamp_test_ni,
  input logic       blank_ni,
  input logic       ripple_i,
  input logic [6:0] seg_o,
  input logic       ripple_o
);
  // R1
  lamp_test_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lamp_test_ni |=> (seg_o == 7'h7F) && !ripple_o);

  // R2
  blank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && !blank_ni) |=> (seg_o == 7'h00));

  // R4
  illegal_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && blank_ni && !hold_i && digit_i > 4'd9) |=> (seg_o == 7'h00));

  // R5
  zero_suppress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && blank_ni && ripple_i && !hold_i && digit_i == 4'd0)
      |=> (seg_o == 7'h00) && ripple_o);

  // R8
  ripple_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && !hold_i) |=> (ripple_o == ($past(ripple_i) && $past(digit_i) == 4'd0)));

  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i) && $stable(lamp_test_ni) && $stable(blank_ni) && $stable(ripple_i))
      |=> $stable(seg_o) && $stable(ripple_o));
endmodule

bind bcd7_latch_decoder bcd7_latch_decoder_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .digit_i      (digit_i),
  .hold_i       (hold_i),
  .lamp_test_ni (lamp_test_ni),
  .blank_ni     (blank_ni),
  .ripple_i     (ripple_i),
  .seg_o        (seg_o),
  .ripple_o     (ripple_o)
);

// File: tb/bcd7_latch_decoder_test.sv
`timescale 1ns/1ps
module bcd7_latch_decoder_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] digit_i = 4'd0;
  logic       hold_i = 1'b0;
  logic       lamp_test_ni = 1'b1;
  logic       blank_ni = 1'b1;
  logic       ripple_i = 1'b0;
  logic [6:0] seg_o;
  logic       ripple_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] mdl_store = 4'd0;

  always #2.5 clk_i = ~clk_i;

  bcd7_latch_decoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .digit_i(digit_i), .hold_i(hold_i),
    .lamp_test_ni(lamp_test_ni), .blank_ni(blank_ni), .ripple_i(ripple_i),
    .seg_o(seg_o), .ripple_o(ripple_o)
  );

  function automatic logic [6:0] ref_glyph(input logic [3:0] c);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7C, 7'h07, 7'h7F, 7'h67};
    return (c <= 4'd9) ? t[c] : 7'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s seg/rbo actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] d, input logic h, input logic lt,
                       input logic bi, input logic rbi);
    logic [3:0] c;
    logic [6:0] s;
    logic       r;
    string      tag;
    @(negedge clk_i);
    digit_i = d; hold_i = h; lamp_test_ni = lt; blank_ni = bi; ripple_i = rbi;
    c = h ? mdl_store : d;              // R3 model
    if (!h) mdl_store = d;
    r = lt && rbi && (c == 4'd0);       // R8
    if (!lt)                           begin s = 7'h7F; tag = "R1"; end
    else if (!bi)                      begin s = 7'h00; tag = "R2"; end
    else if (c > 4'd9)                 begin s = 7'h00; tag = "R4"; end
    else if (rbi && c == 4'd0)         begin s = 7'h00; tag = "R5"; end
    else if (c == 4'd0)                begin s = 7'h3F; tag = "R6"; end
    else                               begin s = ref_glyph(c); tag = "R7"; end
    if (h) tag = {tag, "/R3"};
    tag = {tag, "/R8/R9"};
    exp_q.push_back({r, s});
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {ripple_o, seg_o}, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 reset", {ripple_o, seg_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // transparent sweep of every combination
    for (int i = 0; i < 128; i++)
      drive(i[3:0], 1'b0, i[4], i[5], i[6]);
    // load each code, then hold it under every other input
    for (int p = 0; p < 16; p++) begin
      drive(p[3:0], 1'b0, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 128; i++)
        drive(i[3:0], 1'b1, i[4], i[5], i[6]);
    end
    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule